// File: doc/BRIEF.md
# RS485 Transmit Direction Controller

This block drives the direction (driver-enable) pin of a half-duplex RS485 transceiver that sits beside a UART transmitter. While nothing is queued for transmission the pin selects receive. As soon as the transmit FIFO or holding register reports data, the pin switches to transmit. The serializer is then held back for one bit time so that the line driver has settled before the start bit goes out.

The pin stays in transmit while characters follow one another. It falls back to receive on the stop-bit-complete strobe of the last queued character, which is the first strobe that arrives with no further data waiting. A polarity control inverts the pin. With the mode switched off, the pin simply mirrors a static level supplied by the host and the serializer may start at once.

The block also produces a transmit-empty flag for the interrupt logic. In this mode the flag means that the whole transmitter, shifter included, has drained.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: With `mode_en` low, one clock after any input change `dir_pin` equals `static_level`, `tx_go` is 1 and `tx_empty` equals `hold_empty`.
- R2: With `mode_en` high and no data queued, `dir_pin` shows receive: logic 1 when `pol_inv` is 0.
- R3: In receive state with `mode_en` high, `tx_avail` high at a clock edge puts `dir_pin` at transmit (logic 0 when `pol_inv` is 0) at that edge. `tx_go` then stays 0 for exactly `BIT_CYCLES` further edges before it rises.
- R4: Once in transmit, `dir_pin` keeps its transmit level until an edge where `stop_done` is 1 and `tx_avail` is 0. At that edge it returns to receive and `tx_go` drops.
- R5: A `stop_done` with `tx_avail` still high keeps `dir_pin` at transmit and `tx_go` at 1 without a gap.
- R6: After returning to receive, new data repeats the full transmit-and-setup sequence with no other input needed.
- R7: `pol_inv` = 1 inverts `dir_pin` in both receive and transmit states.
- R8: With `mode_en` high, `tx_empty` is 1 only in receive state with `tx_avail` and `ser_busy` both 0.
- R9: Dropping `mode_en` abandons any sequence. On re-enabling, the block starts from receive.
- R10: During and just after reset, `dir_pin` is 1, `tx_go` is 0 and `tx_empty` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | Enables automatic direction control |
| pol_inv | input | 1 | Inverts the direction pin |
| static_level | input | 1 | Pin level used while the mode is off |
| tx_avail | input | 1 | Transmit data waiting in FIFO or holding register |
| ser_busy | input | 1 | Serializer is shifting a character |
| stop_done | input | 1 | One-cycle strobe at the end of a stop bit |
| hold_empty | input | 1 | Holding register empty (used for tx_empty when the mode is off) |
| dir_pin | output | 1 | Direction pin to the transceiver |
| tx_go | output | 1 | Permission for the serializer to start |
| tx_empty | output | 1 | Transmit-empty indication for interrupt logic |

## Verification
The bench measures the setup delay edge by edge. A timer off by one would let `tx_go` rise a cycle early or late. It sends back-to-back characters with `tx_avail` high on the stop strobe, where a design that released too soon would put a one-cycle receive glitch on the pin. It also flips `pol_inv` and `mode_en` in the middle of a transfer, which catches a stale sequence that survives a disable. It drives `ser_busy` high while idle, which catches an empty flag that tracks only the holding register.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  typedef enum logic [1:0] {
    ST_RECV  = 2'd0,
    ST_SETUP = 2'd1,
    ST_XMIT  = 2'd2
  } dir_state_e;
endpackage

// File: rtl/rs485_setup_timer.sv
module rs485_setup_timer #(
  parameter int BIT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int CNT_W = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (load)            cnt_q <= LOAD_VAL;
    else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = run && (cnt_q == '0);

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    {1'b0, cnt_q} < (CNT_W+1)'(BIT_CYCLES));
  // R3
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt_q == LOAD_VAL);
endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
  import rs485_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_en,
  input  logic       tx_avail,
  input  logic       stop_done,
  input  logic       setup_done,
  output dir_state_e state_q,
  output dir_state_e state_d,
  output logic       setup_load,
  output logic       setup_run
);
  always_comb begin
    state_d    = state_q;
    setup_load = 1'b0;
    if (!mode_en) begin
      state_d = ST_RECV;
    end else begin
      unique case (state_q)
        ST_RECV: if (tx_avail) begin
          state_d    = ST_SETUP;
          setup_load = 1'b1;
        end
        ST_SETUP: if (setup_done) state_d = ST_XMIT;
        ST_XMIT:  if (stop_done && !tx_avail) state_d = ST_RECV;
        default:  state_d = ST_RECV;
      endcase
    end
  end

  assign setup_run = (state_q == ST_SETUP);

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RECV;
    else     state_q <= state_d;
  end

  // R4
  hold_xmit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_XMIT && mode_en && !stop_done) |=> state_q == ST_XMIT);
  // R5
  back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_XMIT && mode_en && tx_avail) |=> state_q == ST_XMIT);
  // R9
  disable_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_en |=> state_q == ST_RECV);
endmodule

// File: rtl/rs485_pin_stage.sv
module rs485_pin_stage
  import rs485_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_en,
  input  logic       pol_inv,
  input  logic       static_level,
  input  logic       hold_empty,
  input  logic       tx_avail,
  input  logic       ser_busy,
  input  dir_state_e state_d,
  output logic       dir_pin,
  output logic       tx_go,
  output logic       tx_empty
);
  logic drive_on;
  assign drive_on = (state_d != ST_RECV);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_pin  <= 1'b1;
      tx_go    <= 1'b0;
      tx_empty <= 1'b0;
    end else if (!mode_en) begin
      dir_pin  <= static_level;
      tx_go    <= 1'b1;
      tx_empty <= hold_empty;
    end else begin
      dir_pin  <= pol_inv ? drive_on : ~drive_on;
      tx_go    <= (state_d == ST_XMIT);
      tx_empty <= (state_d == ST_RECV) && !tx_avail && !ser_busy;
    end
  end

  // R8
  empty_needs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_en && tx_avail) |=> !tx_empty);
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
#(
  parameter int BIT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_en,
  input  logic pol_inv,
  input  logic static_level,
  input  logic tx_avail,
  input  logic ser_busy,
  input  logic stop_done,
  input  logic hold_empty,
  output logic dir_pin,
  output logic tx_go,
  output logic tx_empty
);
  dir_state_e state_q, state_d;
  logic setup_load, setup_run, setup_done;

  rs485_setup_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .load(setup_load), .run(setup_run), .done(setup_done)
  );

  rs485_dir_fsm u_fsm (
    .clk(clk), .rst(rst), .mode_en(mode_en), .tx_avail(tx_avail),
    .stop_done(stop_done), .setup_done(setup_done),
    .state_q(state_q), .state_d(state_d),
    .setup_load(setup_load), .setup_run(setup_run)
  );

  rs485_pin_stage u_pin (
    .clk(clk), .rst(rst), .mode_en(mode_en), .pol_inv(pol_inv),
    .static_level(static_level), .hold_empty(hold_empty),
    .tx_avail(tx_avail), .ser_busy(ser_busy), .state_d(state_d),
    .dir_pin(dir_pin), .tx_go(tx_go), .tx_empty(tx_empty)
  );

  // R3
  go_needs_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_go && mode_en && $past(mode_en) && $stable(pol_inv) && $past(!rst))
      |-> dir_pin == pol_inv);
  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_en && state_q == ST_RECV && $stable(mode_en) && $stable(pol_inv)
      && $past(!rst)) |-> dir_pin == !pol_inv);
  // R8
  empty_state_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_empty && mode_en && $past(mode_en) && $past(!rst)) |-> state_q == ST_RECV);
endmodule

// File: tb/sim_rs485_dir_ctrl.sv
module sim_rs485_dir_ctrl;
  localparam int BITC = 16;
  localparam int S_RECV = 0, S_SETUP = 1, S_XMIT = 2;

  logic clk = 1'b0;
  logic rst, mode_en, pol_inv, static_level, tx_avail, ser_busy, stop_done, hold_empty;
  logic dir_pin, tx_go, tx_empty;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string tag = "R10";

  int m_state = S_RECV;
  int m_cnt = 0;
  logic e_pin = 1'b1, e_go = 1'b0, e_empty = 1'b0;

  always #10 clk = ~clk;

  rs485_dir_ctrl #(.BIT_CYCLES(BITC)) u0 (
    .clk(clk), .rst(rst), .mode_en(mode_en), .pol_inv(pol_inv),
    .static_level(static_level), .tx_avail(tx_avail), .ser_busy(ser_busy),
    .stop_done(stop_done), .hold_empty(hold_empty),
    .dir_pin(dir_pin), .tx_go(tx_go), .tx_empty(tx_empty)
  );

  function automatic logic pin_for(int st, logic inv);
    logic on;
    on = (st != S_RECV);
    return inv ? on : ~on;
  endfunction

  task automatic check(string req, string name, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, name, act, exp, cyc);
    end
  endtask

  // model of requirements, advanced once per clock edge
  task automatic model_edge();
    if (rst) begin
      m_state = S_RECV; m_cnt = 0;
      e_pin = 1'b1; e_go = 1'b0; e_empty = 1'b0;
    end else if (!mode_en) begin
      m_state = S_RECV;
      e_pin = static_level; e_go = 1'b1; e_empty = hold_empty;
    end else begin
      case (m_state)
        S_RECV:  if (tx_avail) begin m_state = S_SETUP; m_cnt = BITC - 1; end
        S_SETUP: if (m_cnt == 0) m_state = S_XMIT; else m_cnt--;
        default: if (stop_done && !tx_avail) m_state = S_RECV;
      endcase
      e_pin = pin_for(m_state, pol_inv);
      e_go = (m_state == S_XMIT);
      e_empty = (m_state == S_RECV) && !tx_avail && !ser_busy;
    end
  endtask

  task automatic step();
    model_edge();
    @(negedge clk);
    cyc++;
    check(tag, "dir_pin", dir_pin, e_pin);
    check(tag, "tx_go", tx_go, e_go);
    check(tag, "tx_empty", tx_empty, e_empty);
  endtask

  task automatic drive(logic a, logic b, logic s);
    tx_avail = a; ser_busy = b; stop_done = s;
  endtask

  initial begin
    int unsigned seed;
    int n;
    seed = $urandom(32'd4242);
    rst = 1'b1; mode_en = 1'b1; pol_inv = 1'b0; static_level = 1'b0;
    tx_avail = 1'b0; ser_busy = 1'b0; stop_done = 1'b0; hold_empty = 1'b1;
    @(negedge clk);
    tag = "R10"; step(); step();
    rst = 1'b0;

    tag = "R2"; drive(0, 0, 0); step(); step();
    check("R2", "idle pin high", dir_pin, 1'b1);

    // R3: setup delay measured directly
    tag = "R3"; drive(1, 0, 0); step();
    check("R3", "pin low on first edge", dir_pin, 1'b0);
    n = 0;
    while (!tx_go && n < 100) begin step(); n++; end
    check("R3", "setup edges == BIT_CYCLES", (n == BITC), 1'b1);

    // R5: back-to-back characters, pin must not glitch
    tag = "R5"; drive(1, 1, 0);
    for (int k = 0; k < 3; k++) begin
      for (int j = 0; j < 5; j++) step();
      drive(1, 1, 1); step();
      check("R5", "pin stays low across stop", dir_pin, 1'b0);
      check("R5", "go stays high across stop", tx_go, 1'b1);
      drive(1, 1, 0);
    end

    // R4: last character ends
    tag = "R4"; drive(0, 1, 0); step(); step();
    check("R4", "pin held before last stop", dir_pin, 1'b0);
    drive(0, 0, 1); step();
    check("R4", "pin released after last stop", dir_pin, 1'b1);
    drive(0, 0, 0); step();

    // R8: shifter busy while idle blocks empty flag
    tag = "R8"; drive(0, 1, 0); step();
    check("R8", "busy blocks empty", tx_empty, 1'b0);
    drive(0, 0, 0); step();
    check("R8", "empty when drained", tx_empty, 1'b1);

    // R6: data later reasserts with full setup
    tag = "R6"; drive(1, 0, 0); step();
    check("R6", "reassert pin", dir_pin, 1'b0);
    check("R6", "go held back", tx_go, 1'b0);
    for (int j = 0; j < BITC; j++) step();
    check("R6", "go after setup", tx_go, 1'b1);

    // R7: polarity inversion in transmit and receive
    tag = "R7"; pol_inv = 1'b1; step();
    check("R7", "inverted transmit", dir_pin, 1'b1);
    drive(0, 0, 1); step(); drive(0, 0, 0); step();
    check("R7", "inverted receive", dir_pin, 1'b0);
    pol_inv = 1'b0;

    // R9: disable mid-setup
    tag = "R9"; drive(1, 0, 0); step(); step();
    mode_en = 1'b0; step();
    mode_en = 1'b1; drive(0, 0, 0); step();
    check("R9", "restart in receive", dir_pin, 1'b1);

    // R1: mode off, pin mirrors static level
    tag = "R1"; mode_en = 1'b0;
    for (int j = 0; j < 8; j++) begin
      static_level = j[0]; hold_empty = j[1]; drive(j[2], 0, 0); step();
    end
    check("R1", "go free-running", tx_go, 1'b1);
    mode_en = 1'b1; hold_empty = 1'b1;

    // random mix covering R1..R9
    tag = "R4";
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom;
      tx_avail = (r[3:0] < 6);
      ser_busy = r[4];
      stop_done = (r[9:5] < 3);
      hold_empty = r[10];
      static_level = r[11];
      if (r[23:16] == 8'd0) mode_en = ~mode_en;
      if (r[31:24] == 8'd1) pol_inv = ~pol_inv;
      step();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule